// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Controller

This block sits behind a two-wire serial slave and turns the 16-bit write words it receives into register operations on four DAC channels. Every channel keeps a 12-bit staging (input) register, a 12-bit live (DAC) register that drives the converter code, and a 2-bit power-down mode. The command nibble in the first byte selects one of the following operations:
- load a staging register only;
- load a channel and move every staging register to its live register;
- move everything to live, then stage new data;
- broadcast to all channels;
- update only;
- a power-down write through a channel mask;
- arm readback of one channel.

The slave hands over each received data byte with a strobe. It pulses a signal on the falling clock edge of the acknowledge bit, and it flags any STOP or repeated START as an abort. Register changes are committed only on the acknowledge pulse. A word cut short by an abort leaves every register untouched. The readback bytes are always presented for the channel chosen by the most recent readback command, and the slave shifts them out on a read.

Top module: `quad_dac_regctl`

## Requirements
- R1: The first byte of a word holds the command in bits 7:4 and data bits 11:8 in bits 3:0. The second byte holds data bits 7:0. A two-byte word takes effect in the clock cycle where `ackFall` is sampled after the second byte, and not before.
- R2: Command 0,1,2,3 (for channels A,B,C,D, which are index 0..3) writes the data into that channel's staging and live registers. In the same commit, every other channel's live register takes its staging value.
- R3: Command 4..7 writes the data into the staging register of channel (command−4) only. No live code changes.
- R4: Command 8..11 copies all staging registers, as they were before the word, into the live registers. It then writes the data into the staging register of channel (command−8).
- R5: Command 12 writes the data into all staging and all live registers. Command 13 writes it into all staging registers only.
- R6: Command 14 is a one-byte word. It copies all staging registers to the live registers at the acknowledge of its first byte, ignores bits 3:0, and the next byte is read as a new command.
- R7: Command 15 with low nibble 0000 makes the second byte a power-down write. In that byte, bits 6,5,4,3 are the masks for channels D,C,B,A, and bits 2:1 give the mode. Each masked channel takes the mode. Mode encoding: 00 = active, 01 = floating, 10 = 1 kΩ to ground, 11 = 100 kΩ to ground. `pdMode[2i+1:2i]` is channel i.
- R8: Command 15 with low nibble 0001, 0010, 0100 or 1000 is a one-byte word that selects channel A, B, C or D for readback. `rdHi` = {2'b00, mode, live[11:8]} and `rdLo` = live[7:0] of the selected channel.
- R9: Command 15 with any other low nibble is a one-byte word that changes nothing. The readback selection after reset is channel A.
- R10: An abort at any point before the committing acknowledge discards the partial word. No register changes, and the next byte is taken as a command.
- R11: After reset every staging and live register is zero and every channel is in mode 11.
- R12: A power-down write leaves all staging and live codes unchanged. Returning a channel to mode 00 restores its previous code on `dacCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-on) |
| byteStrobe | input | 1 | One-cycle pulse: `byteData` holds a received data byte |
| byteData | input | 8 | Received data byte |
| ackFall | input | 1 | One-cycle pulse at the falling clock edge of the acknowledge bit |
| xferAbort | input | 1 | One-cycle pulse on STOP or repeated START |
| dacCode | output | 48 | Live codes, channel i at bits 12i+11:12i |
| pdMode | output | 8 | Power-down modes, channel i at bits 2i+1:2i |
| rdHi | output | 8 | Readback high byte for the selected channel |
| rdLo | output | 8 | Readback low byte for the selected channel |

## Verification
A wrong byte-phase state shows up at the next acknowledge as a word decoded from the wrong byte. Typical symptoms are a live code holding a power-down byte, or a one-byte command swallowing the following command. A staging register with a wrong value stays invisible until a transfer command moves it into a live register. For that reason every staging load is followed within one or two words by a transfer, and each commit is compared on all four codes, all modes and the readback bytes in the cycle after the acknowledge. A bad readback selection shows at once on `rdHi`/`rdLo`, and the mode bits in `rdHi` expose a mode register that disagrees with `pdMode`.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int CH_N   = 4;
  localparam int CODE_W = 12;
  localparam int MODE_W = 2;
  localparam int SEL_W  = $clog2(CH_N);

  typedef enum logic [1:0] {
    PH_CMD      = 2'd0,
    PH_CMD_HELD = 2'd1,
    PH_DATA     = 2'd2,
    PH_DATA_HELD = 2'd3
  } phase_t;

  typedef struct packed {
    logic [CH_N-1:0]   loadIn;
    logic [CH_N-1:0]   loadDac;
    logic              xferAll;
    logic [CH_N-1:0]   setMode;
    logic [MODE_W-1:0] modeVal;
    logic              selRead;
    logic [SEL_W-1:0]  readCh;
    logic [CODE_W-1:0] data;
  } dacOp_t;
endpackage

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import quad_dac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteStrobe,
  input  logic [7:0] byteData,
  input  logic       ackFall,
  input  logic       xferAbort,
  output dacOp_t     op
);
  phase_t phase;
  logic [7:0] cmdByte;
  logic [7:0] dataByte;
  logic [3:0] nib;
  logic [3:0] lowNib;
  logic       twoByte;

  assign nib    = cmdByte[7:4];
  assign lowNib = cmdByte[3:0];
  assign twoByte = (nib <= 4'hD) || (nib == 4'hF && lowNib == 4'h0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_CMD;
      cmdByte  <= '0;
      dataByte <= '0;
    end else if (xferAbort) begin
      phase <= PH_CMD;
    end else begin
      unique case (phase)
        PH_CMD: if (byteStrobe) begin
          cmdByte <= byteData;
          phase   <= PH_CMD_HELD;
        end
        PH_CMD_HELD: if (ackFall) phase <= twoByte ? PH_DATA : PH_CMD;
        PH_DATA: if (byteStrobe) begin
          dataByte <= byteData;
          phase    <= PH_DATA_HELD;
        end
        PH_DATA_HELD: if (ackFall) phase <= PH_CMD;
        default: phase <= PH_CMD;
      endcase
    end
  end

  always_comb begin
    op = '0;
    op.data = {lowNib, dataByte};
    if (ackFall && !xferAbort) begin
      if (phase == PH_CMD_HELD) begin
        if (nib == 4'hE) begin
          op.xferAll = 1'b1;
        end else if (nib == 4'hF) begin
          for (int i = 0; i < CH_N; i++) begin
            if (lowNib == 4'(1 << i)) begin
              op.selRead = 1'b1;
              op.readCh  = SEL_W'(i);
            end
          end
        end
      end else if (phase == PH_DATA_HELD) begin
        unique case (nib[3:2])
          2'b00: begin
            op.loadIn[nib[1:0]]  = 1'b1;
            op.loadDac[nib[1:0]] = 1'b1;
            op.xferAll           = 1'b1;
          end
          2'b01: op.loadIn[nib[1:0]] = 1'b1;
          2'b10: begin
            op.xferAll           = 1'b1;
            op.loadIn[nib[1:0]]  = 1'b1;
          end
          default: begin
            if (nib == 4'hC) begin
              op.loadIn  = '1;
              op.loadDac = '1;
            end else if (nib == 4'hD) begin
              op.loadIn = '1;
            end else if (nib == 4'hF) begin
              op.setMode = dataByte[6:3];
              op.modeVal = dataByte[2:1];
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/quad_dac_datapath.sv
module quad_dac_datapath
  import quad_dac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dacOp_t                   op,
  output logic [CH_N*CODE_W-1:0]   dacCode,
  output logic [CH_N*MODE_W-1:0]   pdMode,
  output logic [7:0]               rdHi,
  output logic [7:0]               rdLo
);
  logic [CODE_W-1:0] inReg  [CH_N];
  logic [CODE_W-1:0] dacReg [CH_N];
  logic [MODE_W-1:0] modeReg[CH_N];
  logic [SEL_W-1:0]  selCh;

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inReg[i]   <= '0;
        dacReg[i]  <= '0;
        modeReg[i] <= '1;
      end else begin
        if (op.loadIn[i]) inReg[i] <= op.data;
        if (op.loadDac[i]) dacReg[i] <= op.data;
        else if (op.xferAll) dacReg[i] <= inReg[i];
        if (op.setMode[i]) modeReg[i] <= op.modeVal;
      end
    end
    assign dacCode[i*CODE_W +: CODE_W] = dacReg[i];
    assign pdMode[i*MODE_W +: MODE_W]  = modeReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selCh <= '0;
    else if (op.selRead) selCh <= op.readCh;
  end

  assign rdHi = {2'b00, modeReg[selCh], dacReg[selCh][11:8]};
  assign rdLo = dacReg[selCh][7:0];
endmodule

// File: rtl/quad_dac_regctl.sv
module quad_dac_regctl
  import quad_dac_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   byteStrobe,
  input  logic [7:0]             byteData,
  input  logic                   ackFall,
  input  logic                   xferAbort,
  output logic [CH_N*CODE_W-1:0] dacCode,
  output logic [CH_N*MODE_W-1:0] pdMode,
  output logic [7:0]             rdHi,
  output logic [7:0]             rdLo
);
  dacOp_t opBus;

  quad_dac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteStrobe(byteStrobe), .byteData(byteData),
    .ackFall(ackFall), .xferAbort(xferAbort), .op(opBus)
  );

  quad_dac_datapath u_dp (
    .clk(clk), .rstN(rstN), .op(opBus), .dacCode(dacCode),
    .pdMode(pdMode), .rdHi(rdHi), .rdLo(rdLo)
  );
endmodule

// File: rtl/quad_dac_checker.sv
module quad_dac_checker
  import quad_dac_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   ackFall,
  input dacOp_t                 opBus,
  input logic [CH_N*CODE_W-1:0] dacCode,
  input logic [CH_N*MODE_W-1:0] pdMode,
  input logic [7:0]             rdHi,
  input logic [7:0]             rdLo
);
  // R1 / R10: nothing moves without an acknowledge pulse
  a_r10_codes_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ackFall |=> $stable(dacCode));
  a_r10_modes_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ackFall |=> $stable(pdMode));
  // R8: readback bytes follow only committed state
  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ackFall |=> ($stable(rdHi) && $stable(rdLo)));
  // R3: staging-only loads leave live codes alone
  a_r3_stage_only: assert property (@(posedge clk) disable iff (!rstN)
    (opBus.loadDac == '0 && !opBus.xferAll) |=> $stable(dacCode));
  // R12: a power-down write leaves the codes alone
  a_r12_pd_keeps_code: assert property (@(posedge clk) disable iff (!rstN)
    (opBus.setMode != '0) |=> $stable(dacCode));
  // R8: readback high byte bits 7:6 are zero
  a_r8_hi_pad: assert property (@(posedge clk) disable iff (!rstN)
    rdHi[7:6] == 2'b00);
endmodule

bind quad_dac_regctl quad_dac_checker u_chk (
  .clk(clk), .rstN(rstN), .ackFall(ackFall), .opBus(opBus),
  .dacCode(dacCode), .pdMode(pdMode), .rdHi(rdHi), .rdLo(rdLo)
);

// File: tb/tb_quad_dac_regctl.sv
module tb_quad_dac_regctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteStrobe = 1'b0;
  logic [7:0]  byteData = '0;
  logic        ackFall = 1'b0;
  logic        xferAbort = 1'b0;
  logic [47:0] dacCode;
  logic [7:0]  pdMode;
  logic [7:0]  rdHi;
  logic [7:0]  rdLo;

  int checks = 0;
  int errors = 0;

  logic [11:0] mIn  [4];
  logic [11:0] mDac [4];
  logic [1:0]  mMode[4];
  int          mSel;

  always #2 clk = ~clk;

  quad_dac_regctl dut (
    .clk(clk), .rstN(rstN), .byteStrobe(byteStrobe), .byteData(byteData),
    .ackFall(ackFall), .xferAbort(xferAbort), .dacCode(dacCode),
    .pdMode(pdMode), .rdHi(rdHi), .rdLo(rdLo)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    logic [47:0] eCode;
    logic [7:0]  eMode;
    for (int i = 0; i < 4; i++) begin
      eCode[i*12 +: 12] = mDac[i];
      eMode[i*2 +: 2]   = mMode[i];
    end
    cmp(tag, "dacCode", int'(dacCode[47:24]), int'(eCode[47:24]));
    cmp(tag, "dacCodeLo", int'(dacCode[23:0]), int'(eCode[23:0]));
    cmp(tag, "pdMode", int'(pdMode), int'(eMode));
    cmp(tag, "rdHi", int'(rdHi), int'({2'b00, mMode[mSel], mDac[mSel][11:8]}));
    cmp(tag, "rdLo", int'(rdLo), int'(mDac[mSel][7:0]));
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteStrobe = 1'b1; byteData = b;
    @(negedge clk); byteStrobe = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); ackFall = 1'b1;
    @(negedge clk); ackFall = 1'b0;
  endtask

  task automatic pulseAbort();
    @(negedge clk); xferAbort = 1'b1;
    @(negedge clk); xferAbort = 1'b0;
  endtask

  // expected effect of a committed word, from the requirements
  task automatic modelWord(input logic [7:0] b0, input logic [7:0] b1);
    int c;
    int ch;
    logic [11:0] d;
    logic [11:0] oldIn[4];
    c = int'(b0[7:4]);
    ch = c % 4;
    d = {b0[3:0], b1};
    for (int i = 0; i < 4; i++) oldIn[i] = mIn[i];
    if (c < 4) begin
      for (int i = 0; i < 4; i++) mDac[i] = oldIn[i];
      mIn[ch] = d; mDac[ch] = d;
    end else if (c < 8) begin
      mIn[ch] = d;
    end else if (c < 12) begin
      for (int i = 0; i < 4; i++) mDac[i] = oldIn[i];
      mIn[ch] = d;
    end else if (c == 12) begin
      for (int i = 0; i < 4; i++) begin mIn[i] = d; mDac[i] = d; end
    end else if (c == 13) begin
      for (int i = 0; i < 4; i++) mIn[i] = d;
    end else if (c == 15 && b0[3:0] == 4'h0) begin
      for (int i = 0; i < 4; i++) if (b1[3+i]) mMode[i] = b1[2:1];
    end
  endtask

  task automatic writeWord(input logic [7:0] b0, input logic [7:0] b1);
    sendByte(b0); pulseAck();
    sendByte(b1); pulseAck();
    modelWord(b0, b1);
  endtask

  task automatic oneByte(input logic [7:0] b0);
    sendByte(b0); pulseAck();
    if (b0[7:4] == 4'hE) begin
      for (int i = 0; i < 4; i++) mDac[i] = mIn[i];
    end else if (b0[7:4] == 4'hF) begin
      for (int i = 0; i < 4; i++) if (b0[3:0] == 4'(1 << i)) mSel = i;
    end
  endtask

  function automatic string cmdTag(input int c);
    if (c < 4) return "R2";
    if (c < 8) return "R3";
    if (c < 12) return "R4";
    return "R5";
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] d;
    for (int i = 0; i < 4; i++) begin mIn[i] = '0; mDac[i] = '0; mMode[i] = 2'b11; end
    mSel = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R11");
    cmp("R9", "rdHi default A", int'(rdHi), 8'h30);

    // R1: nothing before the second acknowledge
    sendByte(8'hC5); pulseAck(); sendByte(8'h5A);
    @(negedge clk);
    checkAll("R1");
    pulseAck(); modelWord(8'hC5, 8'h5A);
    checkAll("R1");

    // sweep of data commands 0..13 over several data patterns
    for (int rep = 0; rep < 4; rep++) begin
      for (int c = 0; c < 14; c++) begin
        d = 12'((c * 389 + rep * 1187 + 77) * 13);
        writeWord({4'(c), d[11:8]}, d[7:0]);
        checkAll(cmdTag(c));
        // move staging to live so hidden values surface (R6)
        if (c >= 4 && c < 8) begin
          oneByte(8'hE7);
          checkAll("R6");
        end
      end
    end

    // R6: one-byte update followed at once by another command
    writeWord(8'h4A, 8'hBC);
    oneByte(8'hE0);
    writeWord(8'h53, 8'h21);
    checkAll("R6");
    oneByte(8'hEF);
    checkAll("R6");

    // R8: readback of each channel
    for (int ch = 0; ch < 4; ch++) begin
      oneByte({4'hF, 4'(1 << ch)});
      checkAll("R8");
    end

    // R7 / R12: all masks, modes cycling
    for (int m = 0; m < 16; m++) begin
      writeWord(8'hF0, {1'b0, 4'(m), 2'(m % 4), 1'b0});
      checkAll("R7");
      for (int ch = 0; ch < 4; ch++) begin
        oneByte({4'hF, 4'(1 << ch)});
        checkAll("R12");
      end
    end
    writeWord(8'hF0, 8'b0111_1000);
    checkAll("R12");

    // R9: other 1111 patterns leave everything, including selection
    oneByte(8'hF4);
    for (int p = 3; p < 16; p++) begin
      if (p != 4 && p != 8) begin
        oneByte({4'hF, 4'(p)});
        checkAll("R9");
      end
    end
    writeWord(8'h1A, 8'h55);
    checkAll("R9");

    // R10: aborts at each stage discard the word
    sendByte(8'hCF); pulseAbort(); pulseAck();
    checkAll("R10");
    sendByte(8'hCF); pulseAck(); pulseAbort();
    sendByte(8'h4E); pulseAck();
    sendByte(8'hEE); pulseAbort(); pulseAck();
    checkAll("R10");
    sendByte(8'hF0); pulseAck(); sendByte(8'h7E); pulseAbort(); pulseAck();
    checkAll("R10");
    writeWord(8'h22, 8'h33);
    checkAll("R10");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule